// File: doc/BRIEF.md
# Clock-Synchronous Serial Port

This block is an 8-bit serial port that shifts data in both directions on one shared clock. It sits on a simple register bus. A write to the data address loads the transmit buffer and arms a transfer. A read of the same address returns the last received byte. Bits leave on `txd_o` least significant first, changing on the falling edge of the shift clock. Bits arrive on `rxd_i` and are sampled on the rising edge.

The shift clock comes from one of two places. The first is an internal divider: the system clock, optionally pre-divided by 4, is divided by n+1, and a toggle stage turns that into a square wave. The second is an external clock pin. In external mode, a write only arms the port and raises `ready_o`, and shifting follows the external edges. If the buffer is reloaded during a transfer, the next byte follows without a gap.

Flags report the state of the port: transmit buffer empty, shift complete, receive buffer full and overrun. There are two interrupt pulses. The transmit pulse is sourced from either buffer-empty or shift-complete.

Top module: `csio_unit`

## Requirements
- R1: After reset, `txd_o`=1, `sclk_o`=1, `sclk_oe_o`=0, `ready_o`=0 and both interrupt outputs are 0. The status register (address 1: bit0 TBE, bit1 TSC, bit2 RBF, bit3 OE) reads 0x03.
- R2: Transmit data leaves LSB first. Each bit is placed on `txd_o` at a falling edge of the shift clock. After the eighth bit, `txd_o` keeps the value of bit 7.
- R3: Receive data is sampled LSB first on rising edges. After eight bits the byte is readable at address 0, RBF is set and `rx_irq_o` pulses once. Reading address 0 clears RBF.
- R4: With the internal clock (control address 2: bit0 enable, bit1 external clock, bit2 pre-divide by 4, bit3 transmit interrupt on TSC), the period of `sclk_o` is 2*(n+1) system clocks, times 4 when pre-divide is set. Here n is the divisor at address 3. `sclk_o` idles high.
- R5: In internal mode, a write to address 0 starts a transfer. TBE returns to 1 when the byte moves to the shift register, and TSC reads 0 while shifting.
- R6: In external mode, a write arms the port: `ready_o` goes to 1 and `sclk_oe_o` stays 0. Shifting follows falling and rising edges of `sclk_i`, and `ready_o` drops after the first falling edge.
- R7: A byte written while a transfer runs follows the current byte with no gap in the shift clock. TSC stays 0 across the boundary.
- R8: With control bit3 = 0, `tx_irq_o` pulses when TBE rises. With bit3 = 1, it pulses when TSC rises.
- R9: A byte that completes while RBF is 1 sets OE and replaces the receive buffer. A write to the status address clears OE.
- R10: With enable (control bit0) = 0, a write loads the buffer but starts no transfer. It starts once enable is set.
- R11: The control and divisor registers read back the values written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (read side effects) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| sclk_i | input | 1 | External shift clock |
| sclk_o | output | 1 | Internal shift clock |
| sclk_oe_o | output | 1 | Drive enable for `sclk_o` |
| txd_o | output | 1 | Serial data out |
| rxd_i | input | 1 | Serial data in |
| ready_o | output | 1 | Armed and waiting for external clock |
| tx_irq_o | output | 1 | Transmit interrupt pulse |
| rx_irq_o | output | 1 | Receive interrupt pulse |

## Verification
Several properties are checked on every cycle:
- `txd_o` changes only at a falling internal clock edge, or while in external mode.
- The shift clock sits high whenever shifting is complete.
- `ready_o` implies external mode with a transfer pending.
- Interrupt pulses coincide with their flags.
- OE rises only while RBF is set.

Only the bench scenarios can show the bit order, the exact clock period for each divisor, gap-free streaming across a byte boundary, overrun replacement, and external-clock shifting.

// File: rtl/csio_pkg.sv
package csio_pkg;
  localparam int unsigned PRESCALE = 4;

  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;
  localparam logic [1:0] A_DIV  = 2'd3;

  typedef struct packed {
    logic irq_on_tsc;
    logic div4;
    logic ext_clk;
    logic enable;
  } ctrl_t;
endpackage

// File: rtl/csio_brg.sv
module csio_brg #(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned PRE   = csio_pkg::PRESCALE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             div4_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             pulse_o
);
  localparam int unsigned PW = (PRE > 1) ? $clog2(PRE) : 1;

  logic [PW-1:0]    pre_q;
  logic [DIV_W-1:0] cnt_q;
  logic             pre_wrap, tick;

  assign pre_wrap = (pre_q == PW'(PRE - 1));
  assign tick     = ~div4_i | pre_wrap;
  assign pulse_o  = run_i & tick & (cnt_q == '0);

  // held reloaded while idle so the first edge lands a full half period after start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (!run_i) begin
      pre_q <= '0;
      cnt_q <= div_i;
    end else begin
      pre_q <= pre_wrap ? '0 : pre_q + 1'b1;
      if (tick) cnt_q <= (cnt_q == '0) ? div_i : cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/csio_sclk.sv
module csio_sclk #(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned SYNC  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             ext_i,
  input  logic             div4_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             sclk_i,
  output logic             fall_o,
  output logic             rise_o,
  output logic             sclk_o
);
  logic          pulse, int_q;
  logic [SYNC:0] sync_q;
  logic          ext_fall, ext_rise;

  csio_brg #(.DIV_W(DIV_W)) u_brg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_i),
    .div4_i (div4_i),
    .div_i  (div_i),
    .pulse_o(pulse)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     int_q <= 1'b1;
    else if (!run_i) int_q <= 1'b1;
    else if (pulse)  int_q <= ~int_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC-1:0], sclk_i};
  end

  assign ext_fall = sync_q[SYNC] & ~sync_q[SYNC-1];
  assign ext_rise = ~sync_q[SYNC] & sync_q[SYNC-1];

  assign fall_o = ext_i ? ext_fall : (pulse & int_q);
  assign rise_o = ext_i ? ext_rise : (pulse & ~int_q);
  assign sclk_o = int_q;
endmodule

// File: rtl/csio_engine.sv
module csio_engine #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         fall_i,
  input  logic         rise_i,
  input  logic         buf_valid_i,
  input  logic [W-1:0] buf_data_i,
  input  logic         rxd_i,
  output logic         load_o,
  output logic         done_o,
  output logic [W-1:0] rx_byte_o,
  output logic         active_o,
  output logic         started_o,
  output logic         txd_o
);
  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  tx_sr_q, rx_sr_q;
  logic [CW-1:0] cnt_q;
  logic          active_q, started_q, txd_q, shift_rx;

  assign shift_rx  = active_q & started_q & rise_i;
  assign done_o    = shift_rx & (cnt_q == CW'(W - 1));
  // reload on the completing edge keeps the clock running
  assign load_o    = en_i & buf_valid_i & (~active_q | done_o);
  assign rx_byte_o = {rxd_i, rx_sr_q[W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sr_q   <= '0;
      rx_sr_q   <= '0;
      cnt_q     <= '0;
      active_q  <= 1'b0;
      started_q <= 1'b0;
      txd_q     <= 1'b1;
    end else begin
      if (active_q && fall_i) begin
        txd_q     <= tx_sr_q[0];
        tx_sr_q   <= tx_sr_q >> 1;
        started_q <= 1'b1;
      end
      if (shift_rx) begin
        rx_sr_q <= rx_byte_o;
        cnt_q   <= cnt_q + 1'b1;
      end
      if (done_o) active_q <= 1'b0;
      if (load_o) begin
        tx_sr_q  <= buf_data_i;
        active_q <= 1'b1;
        cnt_q    <= '0;
        if (!active_q) started_q <= 1'b0;
      end
    end
  end

  assign active_o  = active_q;
  assign started_o = started_q;
  assign txd_o     = txd_q;
endmodule

// File: rtl/csio_unit.sv
module csio_unit #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              sclk_i,
  output logic              sclk_o,
  output logic              sclk_oe_o,
  output logic              txd_o,
  input  logic              rxd_i,
  output logic              ready_o,
  output logic              tx_irq_o,
  output logic              rx_irq_o
);
  import csio_pkg::*;

  localparam int unsigned DIV_W = DATA_W;
  localparam int unsigned PAD_W = DATA_W - 4;

  ctrl_t             ctrl_q;
  logic [DIV_W-1:0]  div_q;
  logic [DATA_W-1:0] txbuf_q, rxbuf_q;
  logic              tbe_q, rbf_q, oe_q, tx_irq_q, rx_irq_q;
  logic              wr_data, wr_stat, wr_ctrl, wr_div, rd_data;
  logic              fall, rise, load, done, active, started, tsc_w, run_int;
  logic [DATA_W-1:0] rx_byte;
  logic              unused_wdata_hi;

  assign wr_data = wr_i & (addr_i == A_DATA);
  assign wr_stat = wr_i & (addr_i == A_STAT);
  assign wr_ctrl = wr_i & (addr_i == A_CTRL);
  assign wr_div  = wr_i & (addr_i == A_DIV);
  assign rd_data = rd_i & (addr_i == A_DATA);
  assign unused_wdata_hi = ^wdata_i[DATA_W-1:4];

  assign run_int = active & ~ctrl_q.ext_clk;
  assign tsc_w   = ~active;

  csio_sclk #(.DIV_W(DIV_W)) u_sclk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_int),
    .ext_i  (ctrl_q.ext_clk),
    .div4_i (ctrl_q.div4),
    .div_i  (div_q),
    .sclk_i (sclk_i),
    .fall_o (fall),
    .rise_o (rise),
    .sclk_o (sclk_o)
  );

  csio_engine #(.W(DATA_W)) u_engine (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (ctrl_q.enable),
    .fall_i      (fall),
    .rise_i      (rise),
    .buf_valid_i (~tbe_q),
    .buf_data_i  (txbuf_q),
    .rxd_i       (rxd_i),
    .load_o      (load),
    .done_o      (done),
    .rx_byte_o   (rx_byte),
    .active_o    (active),
    .started_o   (started),
    .txd_o       (txd_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      div_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(wdata_i[3:0]);
      if (wr_div)  div_q  <= wdata_i;
    end
  end

  // a write in the same cycle as a load keeps the buffer full
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txbuf_q <= '0;
      tbe_q   <= 1'b1;
    end else begin
      if (wr_data) txbuf_q <= wdata_i;
      if (wr_data)   tbe_q <= 1'b0;
      else if (load) tbe_q <= 1'b1;
    end
  end

  // completion wins over a same-cycle read or clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rxbuf_q <= '0;
      rbf_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      if (done) rxbuf_q <= rx_byte;
      if (done)         rbf_q <= 1'b1;
      else if (rd_data) rbf_q <= 1'b0;
      if (done && rbf_q) oe_q <= 1'b1;
      else if (wr_stat)  oe_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_irq_q <= 1'b0;
      rx_irq_q <= 1'b0;
    end else begin
      tx_irq_q <= ctrl_q.irq_on_tsc ? (done & ~load) : (load & ~wr_data);
      rx_irq_q <= done & ~rbf_q;
    end
  end

  always_comb begin
    unique case (addr_i)
      A_DATA:  rdata_o = rxbuf_q;
      A_STAT:  rdata_o = {{PAD_W{1'b0}}, oe_q, rbf_q, tsc_w, tbe_q};
      A_CTRL:  rdata_o = {{PAD_W{1'b0}}, ctrl_q};
      default: rdata_o = div_q;
    endcase
  end

  assign sclk_oe_o = ctrl_q.enable & ~ctrl_q.ext_clk;
  assign ready_o   = ctrl_q.ext_clk & active & ~started;
  assign tx_irq_o  = tx_irq_q;
  assign rx_irq_o  = rx_irq_q;
endmodule

// File: rtl/csio_chk.sv
module csio_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic txd_o,
  input logic sclk_o,
  input logic ready_o,
  input logic tx_irq_o,
  input logic rx_irq_o,
  input logic tbe,
  input logic tsc,
  input logic rbf,
  input logic oe,
  input logic ext_mode,
  input logic irq_sel
);
  // R2
  txd_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(txd_o) |-> (ext_mode || $fell(sclk_o)));

  // R4
  sclk_idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tsc |-> sclk_o);

  // R6
  ready_armed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (ext_mode && !tsc));

  // R3
  rx_irq_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |-> rbf);

  // R8
  tx_irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_irq_o |-> (irq_sel ? tsc : tbe));

  // R9
  oe_needs_rbf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe) |-> rbf);
endmodule

bind csio_unit csio_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .txd_o    (txd_o),
  .sclk_o   (sclk_o),
  .ready_o  (ready_o),
  .tx_irq_o (tx_irq_o),
  .rx_irq_o (rx_irq_o),
  .tbe      (tbe_q),
  .tsc      (tsc_w),
  .rbf      (rbf_q),
  .oe       (oe_q),
  .ext_mode (ctrl_q.ext_clk),
  .irq_sel  (ctrl_q.irq_on_tsc)
);

// File: tb/csio_unit_tb.sv
module csio_unit_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0, rdata_o;
  logic       sclk_drv = 1'b1, rxd_drv = 1'b0;
  logic       sclk_o, sclk_oe_o, txd_o, ready_o, tx_irq_o, rx_irq_o;
  int         total = 0, bad = 0, cyc = 0, txc = 0, rxc = 0;

  always #5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;
  always @(negedge clk_i) begin
    if (tx_irq_o) txc = txc + 1;
    if (rx_irq_o) rxc = rxc + 1;
  end

  csio_unit u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata_o), .sclk_i(sclk_drv), .sclk_o(sclk_o),
    .sclk_oe_o(sclk_oe_o), .txd_o(txd_o), .rxd_i(rxd_drv), .ready_o(ready_o),
    .tx_irq_o(tx_irq_o), .rx_irq_o(rx_irq_o)
  );

  // {div4, divisor, tx byte, rx byte}
  localparam logic [24:0] VEC [4] = '{
    {1'b0, 8'd0,   8'hA5, 8'h3C},
    {1'b0, 8'd3,   8'h01, 8'h80},
    {1'b1, 8'd1,   8'h80, 8'hFE},
    {1'b1, 8'd255, 8'hC3, 8'h5A}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk_i); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i); addr = a; rd = 1'b1;
    #1 d = rdata_o;
    @(negedge clk_i); rd = 1'b0;
  endtask

  task automatic capture(input int nb, input logic [15:0] pat,
                         output logic [15:0] bits, output int pmin, output int pmax);
    int last;
    logic p;
    bits = '0; pmin = 1 << 30; pmax = 0; last = 0;
    for (int k = 0; k < nb; k++) begin
      p = sclk_o;
      forever begin @(negedge clk_i); if (p && !sclk_o) break; p = sclk_o; end
      if (k > 0) begin
        if (cyc - last < pmin) pmin = cyc - last;
        if (cyc - last > pmax) pmax = cyc - last;
      end
      last = cyc;
      rxd_drv = pat[k];
      p = sclk_o;
      forever begin @(negedge clk_i); if (!p && sclk_o) break; p = sclk_o; end
      bits[k] = txd_o;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0]  d;
    logic [15:0] bits;
    int pmin, pmax, base;

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 txd", txd_o, 1);
    chk("R1 sclk", sclk_o, 1);
    chk("R1 pins", {sclk_oe_o, ready_o, tx_irq_o, rx_irq_o}, 0);
    bus_rd(2'd1, d); chk("R1 status", d, 8'h03);

    // R11 readback
    bus_wr(2'd3, 8'h7E); bus_rd(2'd3, d); chk("R11 divisor", d, 8'h7E);
    bus_wr(2'd2, 8'h0C); bus_rd(2'd2, d); chk("R11 control", d, 8'h0C);

    // vector table: R2 R3 R4
    foreach (VEC[i]) begin
      logic [24:0] v;
      v = VEC[i];
      bus_wr(2'd2, {5'b0, v[24], 2'b01});
      bus_wr(2'd3, v[23:16]);
      base = rxc;
      bus_wr(2'd0, v[15:8]);
      capture(8, {8'h00, v[7:0]}, bits, pmin, pmax);
      chk("R2 tx bits", bits[7:0], v[15:8]);
      chk("R4 period min", pmin, 2 * (v[23:16] + 1) * (v[24] ? 4 : 1));
      chk("R4 period max", pmax, 2 * (v[23:16] + 1) * (v[24] ? 4 : 1));
      repeat (3) @(negedge clk_i);
      chk("R2 hold D7", txd_o, v[15]);
      chk("R4 idle high", sclk_o, 1);
      chk("R3 rx irq", rxc - base, 1);
      bus_rd(2'd1, d); chk("R3 status", d, 8'h07);
      bus_rd(2'd0, d); chk("R3 rx byte", d, v[7:0]);
      bus_rd(2'd1, d); chk("R3 rbf clear", d, 8'h03);
    end

    // R10 disabled: no start
    bus_wr(2'd2, 8'h00);
    bus_wr(2'd3, 8'h00);
    bus_wr(2'd0, 8'h55);
    repeat (30) @(negedge clk_i);
    bus_rd(2'd1, d); chk("R10 no start", d, 8'h02);
    chk("R10 sclk idle", sclk_o, 1);
    bus_wr(2'd2, 8'h01);
    capture(8, 16'h0000, bits, pmin, pmax);
    chk("R10 start on enable", bits[7:0], 8'h55);
    repeat (3) @(negedge clk_i);
    bus_rd(2'd0, d);

    // R8 irq on TSC, R5 flags during shift
    bus_wr(2'd2, 8'h09);
    bus_wr(2'd3, 8'h04);
    base = txc;
    bus_wr(2'd0, 8'h3A);
    bus_rd(2'd1, d); chk("R5 shifting flags", d, 8'h01);
    chk("R8 tsc src early", txc - base, 0);
    capture(8, 16'h0000, bits, pmin, pmax);
    repeat (3) @(negedge clk_i);
    chk("R8 tsc src end", txc - base, 1);
    bus_rd(2'd0, d);

    // R8 irq on TBE
    bus_wr(2'd2, 8'h01);
    base = txc;
    bus_wr(2'd0, 8'hC5);
    repeat (2) @(negedge clk_i);
    chk("R8 tbe src early", txc - base, 1);
    capture(8, 16'h0000, bits, pmin, pmax);
    repeat (3) @(negedge clk_i);
    chk("R8 tbe src end", txc - base, 1);
    chk("R5 tx byte", bits[7:0], 8'hC5);
    bus_rd(2'd0, d);

    // R7 streaming, R9 overrun
    bus_wr(2'd3, 8'h02);
    fork
      capture(16, 16'hC35A, bits, pmin, pmax);
      begin
        bus_wr(2'd0, 8'h96);
        repeat (3) @(negedge clk_i);
        bus_wr(2'd0, 8'h4B);
      end
    join
    chk("R7 stream bits", bits, 16'h4B96);
    chk("R7 no gap min", pmin, 6);
    chk("R7 no gap max", pmax, 6);
    repeat (3) @(negedge clk_i);
    bus_rd(2'd1, d); chk("R9 overrun status", d, 8'h0F);
    bus_rd(2'd0, d); chk("R9 newest byte", d, 8'hC3);
    bus_rd(2'd1, d); chk("R9 oe kept", d, 8'h0B);
    bus_wr(2'd1, 8'h00);
    bus_rd(2'd1, d); chk("R9 oe cleared", d, 8'h03);

    // R6 external clock
    bus_wr(2'd2, 8'h03);
    bus_wr(2'd0, 8'hD2);
    repeat (6) @(negedge clk_i);
    chk("R6 ready armed", ready_o, 1);
    chk("R6 no drive", sclk_oe_o, 0);
    bus_rd(2'd1, d); chk("R6 armed flags", d, 8'h01);
    for (int k = 0; k < 8; k++) begin
      sclk_drv = 1'b0;
      rxd_drv = 8'h69 >> k;
      repeat (6) @(negedge clk_i);
      if (k == 0) chk("R6 ready drops", ready_o, 0);
      sclk_drv = 1'b1;
      repeat (6) @(negedge clk_i);
      bits[k] = txd_o;
    end
    chk("R6 tx bits", bits[7:0], 8'hD2);
    bus_rd(2'd0, d); chk("R6 rx byte", d, 8'h69);
    bus_rd(2'd1, d); chk("R6 done flags", d, 8'h03);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule